// File: doc/BRIEF.md
# Frequency Lock Detector with Hysteresis

The block decides whether a divided-down recovered clock runs at the same frequency as a local reference clock. It counts edges of the divided clock over a fixed window of `2^WIN_LOG2` reference cycles. It takes the absolute difference between that count and the window length, and feeds the result to a two-state hysteresis machine. The detector enters lock only on a small difference (`LOCK_TOL`, 16 counts by default, about 250 ppm of a 65536-cycle window). It leaves lock only on a difference above a wider limit (`UNLOCK_TOL`, 32 counts, about 500 ppm). Between the two limits it keeps its previous state.

The divided clock has its own free-running edge counter. At each window end the reference side raises a toggle request. The divided-clock side answers with a stable snapshot of its counter and a toggle acknowledge. The reference side subtracts the previous snapshot to get the edges seen in the window. If the divided clock has stopped and no acknowledge comes by mid-window, that window counts as zero edges.

While no valid input is present the raw decision can chatter. A debounce filter therefore drives a second output. It changes state only after `FILT_N` consecutive decisions have disagreed with it. Both outputs are available.

The capture machine has three states. From CAP_IDLE it moves to CAP_WAIT at window end. From CAP_WAIT it moves to CAP_EVAL on an acknowledge, or on the mid-window timeout. From CAP_EVAL it returns to CAP_IDLE after one cycle. The hysteresis machine moves from HY_UNLOCKED to HY_LOCKED when a decision has a difference under `LOCK_TOL`. It moves back when a decision has a difference over `UNLOCK_TOL`. The filter machine moves between FL_LOW and FL_HIGH when its run of disagreeing decisions reaches `FILT_N`.

Top module: `freq_lock_detector`

## Requirements
- R1: While reset is asserted and after its release until the first decision, both `lock_raw` and `lock_filt` are low.
- R2: Exactly one decision is made per window of `2^WIN_LOG2` reference cycles, and the window counter restarts from zero after reset.
- R3: From the unlocked state, a decision whose count differs from `2^WIN_LOG2` by strictly less than `LOCK_TOL` sets `lock_raw` high.
- R4: From the locked state, a decision whose difference is strictly greater than `UNLOCK_TOL` sets `lock_raw` low.
- R5: A decision whose difference lies from `LOCK_TOL` to `UNLOCK_TOL` inclusive leaves `lock_raw` unchanged, in either state.
- R6: Divided clocks slower and faster than the reference by the same number of counts produce the same decision.
- R7: If the divided clock delivers no snapshot by the middle of the following window, that window is decided as zero edges (difference `2^WIN_LOG2`), so lock is lost.
- R8: `lock_filt` changes only after `FILT_N` consecutive decisions (4 by default) in which `lock_raw` differs from it. A shorter run of disagreements is forgotten as soon as one decision agrees with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock; all decisions and outputs are in this domain |
| rst_n | input | 1 | Active-low asynchronous reset, resynchronised into the divided-clock domain |
| vco_div_clk | input | 1 | Divided-down recovered clock under measurement |
| lock_raw | output | 1 | Unfiltered lock decision with hysteresis |
| lock_filt | output | 1 | Debounced lock decision |

## Verification
The bench sets the divided-clock period so that each window falls a known number of counts from nominal. It goes after the points where a wrong design gives itself away. A deviation of 24 counts must hold either state; a single-threshold design would drop or take lock there. A deviation of 20 counts must not lock, while 12 must. Negative deviations of the same size must act like positive ones; an unsigned subtraction would wrap and unlock at once. A raw decision that alternates every window must leave the filtered output still; a filter that counts disagreements without clearing would flip after four of them. A stopped divided clock must force unlock through the timeout; without it the capture machine would hang, holding a stale lock.

// File: rtl/fld_pkg.sv
package fld_pkg;

    typedef enum logic [1:0] {
        CAP_IDLE = 2'd0,
        CAP_WAIT = 2'd1,
        CAP_EVAL = 2'd2
    } cap_state_e;

    typedef enum logic {
        HY_UNLOCKED = 1'b0,
        HY_LOCKED   = 1'b1
    } hyst_state_e;

    typedef enum logic {
        FL_LOW  = 1'b0,
        FL_HIGH = 1'b1
    } filt_state_e;

endpackage

// File: rtl/fld_vco_side.sv
module fld_vco_side #(
    parameter int CW = 18
) (
    input  logic          vco_clk,
    input  logic          rst_n,
    input  logic          req_tgl,
    output logic [CW-1:0] snap,
    output logic          ack_tgl
);

    logic [1:0]    rst_sync;
    logic          vrst_n;
    logic [CW-1:0] edge_cnt;
    logic [2:0]    req_sync;
    logic          req_seen;

    // reset release resynchronised to the divided clock
    always_ff @(posedge vco_clk or negedge rst_n) begin
        if (!rst_n) rst_sync <= 2'b00;
        else        rst_sync <= {rst_sync[0], 1'b1};
    end
    assign vrst_n = rst_sync[1];

    // free-running edge counter
    always_ff @(posedge vco_clk or negedge vrst_n) begin
        if (!vrst_n) edge_cnt <= '0;
        else         edge_cnt <= edge_cnt + 1'b1;
    end

    // request toggle synchroniser plus one history stage
    always_ff @(posedge vco_clk or negedge vrst_n) begin
        if (!vrst_n) req_sync <= 3'b000;
        else         req_sync <= {req_sync[1:0], req_tgl};
    end
    assign req_seen = req_sync[1] ^ req_sync[2];

    // snapshot and acknowledge
    always_ff @(posedge vco_clk or negedge vrst_n) begin
        if (!vrst_n) begin
            snap    <= '0;
            ack_tgl <= 1'b0;
        end else if (req_seen) begin
            snap    <= edge_cnt;
            ack_tgl <= ~ack_tgl;
        end
    end

    // R2
    snap_stable_chk: assert property (@(posedge vco_clk) disable iff (!vrst_n)
        (ack_tgl == $past(ack_tgl)) |-> $stable(snap));

endmodule

// File: rtl/fld_window.sv
module fld_window
    import fld_pkg::*;
#(
    parameter int WIN_LOG2 = 16,
    parameter int CW       = WIN_LOG2 + 2
) (
    input  logic          ref_clk,
    input  logic          rst_n,
    input  logic          ack_tgl,
    input  logic [CW-1:0] snap,
    output logic          req_tgl,
    output logic          eval_vld,
    output logic [CW-1:0] diff_o
);

    localparam logic [CW-1:0]       NOM     = CW'(2 ** WIN_LOG2);
    localparam logic [WIN_LOG2-1:0] HALF_M1 = WIN_LOG2'(2 ** (WIN_LOG2 - 1) - 1);

    cap_state_e          state_q, state_d;
    logic [WIN_LOG2-1:0] win_cnt;
    logic                win_end;
    logic                half_pt;
    logic [2:0]          ack_sync;
    logic                ack_edge;
    logic [CW-1:0]       prev_snap;
    logic [CW-1:0]       delta_q;

    assign win_end  = &win_cnt;
    assign half_pt  = (win_cnt == HALF_M1);
    assign ack_edge = ack_sync[1] ^ ack_sync[2];

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) win_cnt <= '0;
        else        win_cnt <= win_cnt + 1'b1;
    end

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) req_tgl <= 1'b0;
        else        req_tgl <= req_tgl ^ win_end;
    end

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) ack_sync <= 3'b000;
        else        ack_sync <= {ack_sync[1:0], ack_tgl};
    end

    // state register
    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) state_q <= CAP_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CAP_IDLE: if (win_end)                 state_d = CAP_WAIT;
            CAP_WAIT: if (ack_edge || half_pt)     state_d = CAP_EVAL;
            CAP_EVAL:                              state_d = CAP_IDLE;
            default:                               state_d = CAP_IDLE;
        endcase
    end

    // measurement registers
    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_snap <= '0;
            delta_q   <= '0;
        end else if (state_q == CAP_WAIT) begin
            if (ack_edge) begin
                delta_q   <= snap - prev_snap;
                prev_snap <= snap;
            end else if (half_pt) begin
                delta_q   <= '0;
            end
        end
    end

    // outputs
    always_comb begin
        eval_vld = (state_q == CAP_EVAL);
        if (delta_q >= NOM) diff_o = delta_q - NOM;
        else                diff_o = NOM - delta_q;
    end

    // R2
    req_at_end_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (req_tgl != $past(req_tgl)) |-> ($past(win_cnt) == {WIN_LOG2{1'b1}}));

    // R2
    eval_pulse_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        eval_vld |=> !eval_vld);

    // R7
    timeout_zero_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (state_q == CAP_WAIT && half_pt && !ack_edge) |=> (eval_vld && diff_o == NOM));

endmodule

// File: rtl/fld_hyst.sv
module fld_hyst
    import fld_pkg::*;
#(
    parameter int CW         = 18,
    parameter int LOCK_TOL   = 16,
    parameter int UNLOCK_TOL = 32
) (
    input  logic          ref_clk,
    input  logic          rst_n,
    input  logic          eval_vld,
    input  logic [CW-1:0] diff,
    output logic          lock_raw,
    output logic          raw_vld
);

    localparam logic [CW-1:0] LOCK_LIM   = CW'(LOCK_TOL);
    localparam logic [CW-1:0] UNLOCK_LIM = CW'(UNLOCK_TOL);

    hyst_state_e state_q, state_d;

    // state register
    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) state_q <= HY_UNLOCKED;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HY_UNLOCKED: if (eval_vld && diff < LOCK_LIM)   state_d = HY_LOCKED;
            HY_LOCKED:   if (eval_vld && diff > UNLOCK_LIM) state_d = HY_UNLOCKED;
            default:                                        state_d = HY_UNLOCKED;
        endcase
    end

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) raw_vld <= 1'b0;
        else        raw_vld <= eval_vld;
    end

    // outputs
    always_comb begin
        lock_raw = (state_q == HY_LOCKED);
    end

    // R3
    lock_rise_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $rose(lock_raw) |-> ($past(eval_vld) && $past(diff) < LOCK_LIM));

    // R4
    lock_fall_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $fell(lock_raw) |-> ($past(eval_vld) && $past(diff) > UNLOCK_LIM));

    // R5
    band_hold_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (eval_vld && diff >= LOCK_LIM && diff <= UNLOCK_LIM) |=> $stable(lock_raw));

endmodule

// File: rtl/fld_filter.sv
module fld_filter
    import fld_pkg::*;
#(
    parameter int FILT_N = 4
) (
    input  logic ref_clk,
    input  logic rst_n,
    input  logic raw_vld,
    input  logic lock_raw,
    output logic lock_filt
);

    localparam int            RW   = $clog2(FILT_N + 1);
    localparam logic [RW-1:0] LAST = RW'(FILT_N - 1);

    filt_state_e state_q, state_d;
    logic [RW-1:0] run_q, run_d;
    logic          disagree;

    assign disagree = lock_raw ^ (state_q == FL_HIGH);

    // state register
    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FL_LOW;
            run_q   <= '0;
        end else begin
            state_q <= state_d;
            run_q   <= run_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        run_d   = run_q;
        if (raw_vld) begin
            if (!disagree) begin
                run_d = '0;
            end else if (run_q == LAST) begin
                run_d = '0;
                unique case (state_q)
                    FL_LOW:  state_d = FL_HIGH;
                    FL_HIGH: state_d = FL_LOW;
                    default: state_d = FL_LOW;
                endcase
            end else begin
                run_d = run_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        lock_filt = (state_q == FL_HIGH);
    end

    // R8
    filt_quiet_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        !raw_vld |=> $stable(lock_filt));

    // R8
    filt_rise_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $rose(lock_filt) |-> $past(lock_raw));

    // R8
    filt_fall_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $fell(lock_filt) |-> !$past(lock_raw));

endmodule

// File: rtl/freq_lock_detector.sv
module freq_lock_detector #(
    parameter int WIN_LOG2   = 16,
    parameter int LOCK_TOL   = 16,
    parameter int UNLOCK_TOL = 32,
    parameter int FILT_N     = 4
) (
    input  logic ref_clk,
    input  logic rst_n,
    input  logic vco_div_clk,
    output logic lock_raw,
    output logic lock_filt
);

    localparam int CW = WIN_LOG2 + 2;

    logic          req_tgl;
    logic          ack_tgl;
    logic [CW-1:0] snap;
    logic          eval_vld;
    logic [CW-1:0] diff;
    logic          raw_vld;

    fld_vco_side #(.CW(CW)) u_vco (
        .vco_clk (vco_div_clk),
        .rst_n   (rst_n),
        .req_tgl (req_tgl),
        .snap    (snap),
        .ack_tgl (ack_tgl)
    );

    fld_window #(.WIN_LOG2(WIN_LOG2), .CW(CW)) u_win (
        .ref_clk  (ref_clk),
        .rst_n    (rst_n),
        .ack_tgl  (ack_tgl),
        .snap     (snap),
        .req_tgl  (req_tgl),
        .eval_vld (eval_vld),
        .diff_o   (diff)
    );

    fld_hyst #(.CW(CW), .LOCK_TOL(LOCK_TOL), .UNLOCK_TOL(UNLOCK_TOL)) u_hyst (
        .ref_clk  (ref_clk),
        .rst_n    (rst_n),
        .eval_vld (eval_vld),
        .diff     (diff),
        .lock_raw (lock_raw),
        .raw_vld  (raw_vld)
    );

    fld_filter #(.FILT_N(FILT_N)) u_filt (
        .ref_clk   (ref_clk),
        .rst_n     (rst_n),
        .raw_vld   (raw_vld),
        .lock_raw  (lock_raw),
        .lock_filt (lock_filt)
    );

    // R1
    reset_low_chk: assert property (@(posedge ref_clk)
        !rst_n |-> (!lock_raw && !lock_filt));

endmodule

// File: tb/freq_lock_detector_test.sv
`timescale 1ps/1ps
module freq_lock_detector_test;

    localparam int WL      = 10;
    localparam int WIN     = 1 << WL;
    localparam int LTOL    = 16;
    localparam int UTOL    = 32;
    localparam int FN      = 4;
    localparam int STOP_D  = 1000;
    localparam int RES_D   = 2000;

    logic ref_clk = 1'b0;
    logic vco_clk = 1'b0;
    logic rst_n   = 1'b0;
    logic lock_raw, lock_filt;

    int  hp      = 2000;
    bit  vco_run = 1'b1;
    int  cyc     = 0;
    int  k       = 0;
    int  checks  = 0;
    int  fails   = 0;
    bit  done    = 1'b0;

    bit    m_raw  = 1'b0;
    bit    m_filt = 1'b0;
    int    m_run  = 0;
    string prev_tag = "R1";

    freq_lock_detector #(.WIN_LOG2(WL), .LOCK_TOL(LTOL), .UNLOCK_TOL(UTOL), .FILT_N(FN)) uut (
        .ref_clk     (ref_clk),
        .rst_n       (rst_n),
        .vco_div_clk (vco_clk),
        .lock_raw    (lock_raw),
        .lock_filt   (lock_filt)
    );

    always #2000 ref_clk = ~ref_clk;

    always begin
        if (vco_run) begin
            #(hp);
            vco_clk = ~vco_clk;
        end else begin
            #(1000);
        end
    end

    always @(posedge ref_clk) if (rst_n) cyc <= cyc + 1;

    function automatic int half_per(int d);
        return (WIN * 2000) / (WIN + d);
    endfunction

    function automatic int dev_of(int d);
        if (d == STOP_D || d == RES_D) return WIN;
        return d;
    endfunction

    function automatic bit next_raw(bit prev, int dev);
        int a = (dev < 0) ? -dev : dev;
        if (!prev && a < LTOL) return 1'b1;
        if (prev && a > UTOL)  return 1'b0;
        return prev;
    endfunction

    task automatic model_step(int dev);
        m_raw = next_raw(m_raw, dev);
        if (m_raw != m_filt) begin
            m_run++;
            if (m_run == FN) begin
                m_filt = m_raw;
                m_run  = 0;
            end
        end else begin
            m_run = 0;
        end
    endtask

    task automatic check(bit act, bit exp, string tag, string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s window %0d: actual %0b expected %0b", tag, what, k, act, exp);
        end
    endtask

    task automatic wait_cyc(int n);
        while (cyc < n) @(negedge ref_clk);
    endtask

    task automatic apply(int d);
        if (d == STOP_D) begin
            vco_run = 1'b0;
        end else begin
            hp      = half_per((d == RES_D) ? 0 : d);
            vco_run = 1'b1;
        end
    endtask

    // one window: set its deviation, check the previous window's decision
    task automatic do_window(int d, string tag);
        int at = (d == RES_D) ? 100 : 20;
        wait_cyc(k * WIN + at);
        apply(d);
        wait_cyc(k * WIN + 768);
        check(lock_raw,  m_raw,  prev_tag, "lock_raw");
        check(lock_filt, m_filt, prev_tag, "lock_filt");
        model_step(dev_of(d));
        prev_tag = tag;
        k++;
    endtask

    initial begin
        int seed;
        int pick;
        int set_v [11] = '{0, 5, -5, 10, -10, 24, -24, 40, -40, 60, -60};
        seed = $urandom(32'd4242);
        repeat (5) @(negedge ref_clk);
        // R1: outputs low during reset
        check(lock_raw,  1'b0, "R1", "lock_raw in reset");
        check(lock_filt, 1'b0, "R1", "lock_filt in reset");
        rst_n = 1'b1;

        for (int i = 0; i < 6; i++) do_window(0, "R3");
        for (int i = 0; i < 2; i++) do_window(24, "R5");
        for (int i = 0; i < 5; i++) do_window(40, "R4");
        for (int i = 0; i < 2; i++) do_window(24, "R5");
        do_window(20, "R5");
        for (int i = 0; i < 5; i++) do_window(12, "R3");
        for (int i = 0; i < 3; i++) begin
            do_window(60, "R8");
            do_window(0, "R8");
        end
        for (int i = 0; i < 5; i++) do_window(-40, "R6");
        for (int i = 0; i < 5; i++) do_window(-12, "R6");
        for (int i = 0; i < 5; i++) do_window(STOP_D, "R7");
        do_window(RES_D, "R7");
        for (int i = 0; i < 5; i++) do_window(0, "R3");
        for (int i = 0; i < 16; i++) begin
            pick = int'($urandom % 11);
            do_window(set_v[pick], "R2");
        end
        do_window(0, "R2");

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        #(64'd600_000_000);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule